// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits between a 32-bit CPU data port and an external memory bus of 8 or 16 data bits. It compares each CPU word address against eight programmable areas, picks the lowest-numbered area that matches, and raises that area's active-low chip select. It then runs one or more external bus cycles, stretched by the area's own wait count. An area set to 8 bits splits a word access into up to four byte cycles. An area set to 16 bits splits it into up to two halfword cycles. Each area also has its own byte ordering, which decides how the CPU byte lanes map onto memory bytes.

The CPU starts a transfer with a one-clock request pulse while the block is idle. It gives a word address, byte strobes and, for a write, the data. It then waits for a one-clock ready pulse, which carries the read data and an error flag. An address that falls in no enabled area drives no chip select. It still takes a base-length cycle, then finishes with the error flag set.

The area settings are static configuration inputs. They are changed only while the block is idle.

Top module: `xbus_cs_ctrl`

## Requirements
- R1: Area i matches when cfg_en[i] is 1 and ((cpu_addr[24:16] XOR base_i) AND NOT mask_i) is zero. A 1 in a mask bit means "don't care". Address bits below 16 are never compared. While the external cycles of an access run, ext_cs_n is all ones except bit i, which is low.
- R2: When several enabled areas match, the one with the lowest index drives its chip select.
- R3: Each external bus cycle lasts 2+W clocks, where W is the area's 3-bit wait value (0..7). The first clock has ext_rd_n and ext_wr_n both high. In the remaining 1+W clocks, ext_rd_n is low for a read, or ext_wr_n is low for a write, never both.
- R4: cfg_wide[i]=1 selects a 16-bit bus and 0 selects an 8-bit bus. A 16-bit bus carries byte offsets {0,1} and {2,3} in two cycles. An 8-bit bus carries one byte offset per cycle. Only cycles that carry at least one strobed byte are run, in increasing offset order. ext_addr is {cpu_addr[24:2], offset of the cycle's lowest byte}.
- R5: Byte offset k of the word maps to CPU lane 3-k (big-endian). When cfg_le_en=1 and the area equals cfg_le_area, it maps to lane k instead (little-endian). Lane j is bits [8j+7:8j]. On a 16-bit bus the even offset uses ext_dout/ext_din[15:8] and ext_be[1], and the odd offset uses [7:0] and ext_be[0]. On an 8-bit bus the byte uses [7:0] and ext_be[0], and ext_be[1] is 0.
- R6: For a read, ext_din is taken in the last clock of each bus cycle. The strobed lanes of cpu_rdata hold the memory bytes and the unstrobed lanes read as zero.
- R7: For a write, ext_oe is high through every clock of the write cycles and low otherwise. ext_dout carries the mapped write bytes.
- R8: cpu_rdy is high for exactly one clock, in the clock right after the last external bus clock. The latency from the request edge is the number of cycles times (2+W) clocks.
- R9: An address that matches no enabled area asserts no chip select and no strobe for 2 clocks. It then gives cpu_rdy with cpu_err=1 and cpu_rdata=0. A hit gives cpu_err=0.
- R10: During reset, ext_cs_n is all ones, ext_rd_n and ext_wr_n are high, and ext_oe and cpu_rdy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-clock access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 23 | Word address, bits [24:2] |
| cpu_be | input | 4 | Byte strobes per CPU lane |
| cpu_wdata | input | 32 | Write data |
| cpu_rdy | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_rdy |
| cpu_err | output | 1 | No area matched, valid with cpu_rdy |
| cfg_en | input | 8 | Area enables |
| cfg_base | input | 72 | Per-area 9-bit base, area i at [9i+8:9i] |
| cfg_mask | input | 72 | Per-area 9-bit don't-care mask |
| cfg_wait | input | 24 | Per-area 3-bit wait count |
| cfg_wide | input | 8 | Per-area bus width, 1 = 16 bits |
| cfg_le_en | input | 1 | Enables little-endian for one area |
| cfg_le_area | input | 3 | Index of the little-endian area |
| ext_addr | output | 25 | External byte address |
| ext_cs_n | output | 8 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_be | output | 2 | Byte enables on the external bus |
| ext_dout | output | 16 | External write data |
| ext_oe | output | 1 | Write data drive enable |
| ext_din | input | 16 | External read data |

## Verification
A wrong latched area index or wait count shows up in the first bus clock of an access. It appears there as the wrong chip-select bit, or as a strobe phase of the wrong length. A corrupted pending-cycle set or endianness flag shows up within one bus cycle as a wrong external address, byte enable or data byte. Otherwise it shows at ready time as a wrong cycle count or wrong read lanes. A broken decode priority or miss path shows at once as the wrong chip select, or as an error flag that disagrees with the address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CPU_W  = 32;
    localparam int LANES  = CPU_W / 8;
    localparam int EXT_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_DONE = 2'd2
    } xbus_state_e;

    // CPU lane that holds byte offset 'off' of the word
    function automatic logic [1:0] lane_of(input logic [1:0] off, input logic le);
        return le ? off : (2'd3 - off);
    endfunction

    // index of the lowest pending bus cycle
    function automatic logic [1:0] first_beat(input logic [3:0] p);
        logic [1:0] b;
        b = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (p[i]) b = 2'(i);
        end
        return b;
    endfunction

endpackage

// File: rtl/xbus_area_decode.sv
module xbus_area_decode #(
    parameter int N  = 8,
    parameter int RW = 9
) (
    input  logic [RW-1:0]          addr_hi,
    input  logic [N-1:0]           en,
    input  logic [N*RW-1:0]        base,
    input  logic [N*RW-1:0]        mask,
    output logic [N-1:0]           match,
    output logic                   hit,
    output logic [$clog2(N)-1:0]   idx
);
    localparam int IW = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_area
        assign match[g] = en[g] &&
            (((addr_hi ^ base[g*RW +: RW]) & ~mask[g*RW +: RW]) == '0);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/xbus_beat_plan.sv
module xbus_beat_plan
    import xbus_pkg::*;
(
    input  logic [3:0] be,
    input  logic       wide,
    input  logic       le,
    output logic [3:0] pend
);
    always_comb begin
        pend = '0;
        if (wide) begin
            for (int b = 0; b < 2; b++) begin
                pend[b] = be[lane_of(2'(2*b), le)] | be[lane_of(2'(2*b+1), le)];
            end
        end else begin
            for (int k = 0; k < 4; k++) begin
                pend[k] = be[lane_of(2'(k), le)];
            end
        end
    end
endmodule

// File: rtl/xbus_lane_mux.sv
module xbus_lane_mux
    import xbus_pkg::*;
(
    input  logic [1:0]        beat,
    input  logic              wide,
    input  logic              le,
    input  logic [CPU_W-1:0]  wdata,
    input  logic [LANES-1:0]  be,
    input  logic [CPU_W-1:0]  acc,
    input  logic [EXT_W-1:0]  din,
    output logic [EXT_W-1:0]  dout,
    output logic [1:0]        bsel,
    output logic [CPU_W-1:0]  merged
);
    logic [1:0] lh, ll;

    always_comb begin
        merged = acc;
        if (wide) begin
            lh = lane_of({beat[0], 1'b0}, le);
            ll = lane_of({beat[0], 1'b1}, le);
            dout = {wdata[8*lh +: 8], wdata[8*ll +: 8]};
            bsel = {be[lh], be[ll]};
            if (be[lh]) merged[8*lh +: 8] = din[15:8];
            if (be[ll]) merged[8*ll +: 8] = din[7:0];
        end else begin
            lh = lane_of(beat, le);
            ll = lh;
            dout = {8'h00, wdata[8*lh +: 8]};
            bsel = {1'b0, be[lh]};
            if (be[lh]) merged[8*lh +: 8] = din[7:0];
        end
    end
endmodule

// File: rtl/xbus_cs_ctrl.sv
module xbus_cs_ctrl
    import xbus_pkg::*;
#(
    parameter int N_AREA = 8,
    parameter int ADDR_W = 25,
    parameter int GRAN_W = 16,
    parameter int WAIT_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:2]            cpu_addr,
    input  logic [LANES-1:0]             cpu_be,
    input  logic [CPU_W-1:0]             cpu_wdata,
    output logic                         cpu_rdy,
    output logic [CPU_W-1:0]             cpu_rdata,
    output logic                         cpu_err,
    input  logic [N_AREA-1:0]            cfg_en,
    input  logic [N_AREA*(ADDR_W-GRAN_W)-1:0] cfg_base,
    input  logic [N_AREA*(ADDR_W-GRAN_W)-1:0] cfg_mask,
    input  logic [N_AREA*WAIT_W-1:0]     cfg_wait,
    input  logic [N_AREA-1:0]            cfg_wide,
    input  logic                         cfg_le_en,
    input  logic [$clog2(N_AREA)-1:0]    cfg_le_area,
    output logic [ADDR_W-1:0]            ext_addr,
    output logic [N_AREA-1:0]            ext_cs_n,
    output logic                         ext_rd_n,
    output logic                         ext_wr_n,
    output logic [1:0]                   ext_be,
    output logic [EXT_W-1:0]             ext_dout,
    output logic                         ext_oe,
    input  logic [EXT_W-1:0]             ext_din
);
    localparam int RW = ADDR_W - GRAN_W;
    localparam int IW = $clog2(N_AREA);
    localparam int CW = WAIT_W + 1;

    typedef struct packed {
        xbus_state_e        st;
        logic [ADDR_W-3:0]  addr;
        logic               we;
        logic [CPU_W-1:0]   wdata;
        logic [LANES-1:0]   be;
        logic               hit;
        logic [IW-1:0]      area;
        logic               wide;
        logic               le;
        logic [WAIT_W-1:0]  wt;
        logic [3:0]         pend;
        logic [CW-1:0]      cnt;
        logic [CPU_W-1:0]   rdata;
        logic               err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // decode of the incoming request
    logic [N_AREA-1:0] dec_match;
    logic              dec_hit;
    logic [IW-1:0]     dec_idx;
    logic              dec_wide;
    logic              dec_le;
    logic [3:0]        dec_pend;

    xbus_area_decode #(.N(N_AREA), .RW(RW)) u_dec (
        .addr_hi (cpu_addr[ADDR_W-1:GRAN_W]),
        .en      (cfg_en),
        .base    (cfg_base),
        .mask    (cfg_mask),
        .match   (dec_match),
        .hit     (dec_hit),
        .idx     (dec_idx)
    );

    assign dec_wide = cfg_wide[dec_idx];
    assign dec_le   = cfg_le_en && (cfg_le_area == dec_idx);

    xbus_beat_plan u_plan (
        .be   (cpu_be),
        .wide (dec_wide),
        .le   (dec_le),
        .pend (dec_pend)
    );

    // lane routing of the cycle in progress
    logic [1:0]       beat;
    logic [EXT_W-1:0] mux_dout;
    logic [1:0]       mux_be;
    logic [CPU_W-1:0] mux_rdata;

    assign beat = first_beat(ctl_q.pend);

    xbus_lane_mux u_mux (
        .beat   (beat),
        .wide   (ctl_q.wide),
        .le     (ctl_q.le),
        .wdata  (ctl_q.wdata),
        .be     (ctl_q.be),
        .acc    (ctl_q.rdata),
        .din    (ext_din),
        .dout   (mux_dout),
        .bsel   (mux_be),
        .merged (mux_rdata)
    );

    logic          last_clk;
    logic [3:0]    pend_rest;

    assign last_clk  = (ctl_q.cnt == ({1'b0, ctl_q.wt} + CW'(1)));
    assign pend_rest = ctl_q.pend & ~(4'b0001 << beat);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    ctl_d.addr  = cpu_addr;
                    ctl_d.we    = cpu_we;
                    ctl_d.wdata = cpu_wdata;
                    ctl_d.be    = cpu_be;
                    ctl_d.hit   = dec_hit;
                    ctl_d.area  = dec_idx;
                    ctl_d.wide  = dec_wide;
                    ctl_d.le    = dec_le;
                    ctl_d.wt    = dec_hit ? cfg_wait[dec_idx*WAIT_W +: WAIT_W] : '0;
                    ctl_d.pend  = dec_hit ? dec_pend : 4'b0001;
                    ctl_d.cnt   = '0;
                    ctl_d.rdata = '0;
                    ctl_d.err   = !dec_hit;
                    ctl_d.st    = (dec_hit && dec_pend == 4'b0000) ? ST_DONE : ST_BUS;
                end
            end
            ST_BUS: begin
                if (last_clk) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.hit) begin
                        if (!ctl_q.we) ctl_d.rdata = mux_rdata;
                        ctl_d.pend = pend_rest;
                        if (pend_rest == 4'b0000) ctl_d.st = ST_DONE;
                    end else begin
                        ctl_d.pend = 4'b0000;
                        ctl_d.st   = ST_DONE;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CW'(1);
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // port drive
    logic busy, active, strobe;
    logic [1:0] off;

    assign busy   = (ctl_q.st == ST_BUS);
    assign active = busy && ctl_q.hit;
    assign strobe = active && (ctl_q.cnt != '0);
    assign off    = ctl_q.wide ? {beat[0], 1'b0} : beat;

    assign ext_addr  = {ctl_q.addr, off};
    assign ext_cs_n  = active ? ~(N_AREA'(1) << ctl_q.area) : '1;
    assign ext_rd_n  = !(strobe && !ctl_q.we);
    assign ext_wr_n  = !(strobe && ctl_q.we);
    assign ext_be    = active ? mux_be : 2'b00;
    assign ext_oe    = active && ctl_q.we;
    assign ext_dout  = (active && ctl_q.we) ? mux_dout : '0;
    assign cpu_rdy   = (ctl_q.st == ST_DONE);
    assign cpu_rdata = cpu_rdy ? ctl_q.rdata : '0;
    assign cpu_err   = cpu_rdy && ctl_q.err;

    // assertions
    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && cpu_req && dec_hit) |->
        ((dec_match & ((N_AREA'(1) << dec_idx) - N_AREA'(1))) == '0));

    assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctl_q.cnt <= ({1'b0, ctl_q.wt} + CW'(1))));

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    assert_strobe_has_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> !(&ext_cs_n));

    assert_narrow_upper_be_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ctl_q.wide) |-> (ext_be[1] == 1'b0));

    assert_rdy_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy);

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_q.hit) |-> ((&ext_cs_n) && ext_rd_n && ext_wr_n && !ext_oe));

endmodule

// File: tb/xbus_cs_ctrl_test.sv
module xbus_cs_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [24:2] cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rdy, cpu_err;
    logic [31:0] cpu_rdata;
    logic [7:0]  cfg_en = '0, cfg_wide = '0;
    logic [71:0] cfg_base, cfg_mask;
    logic [23:0] cfg_wait;
    logic        cfg_le_en = 1'b0;
    logic [2:0]  cfg_le_area = '0;
    logic [24:0] ext_addr;
    logic [7:0]  ext_cs_n;
    logic        ext_rd_n, ext_wr_n, ext_oe;
    logic [1:0]  ext_be;
    logic [15:0] ext_dout, ext_din;
    logic        cur_wide = 1'b0;

    logic [8:0]  c_base[8];
    logic [8:0]  c_mask[8];
    logic [2:0]  c_wait[8];

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < 8; g++) begin : g_cfg
        assign cfg_base[g*9 +: 9] = c_base[g];
        assign cfg_mask[g*9 +: 9] = c_mask[g];
        assign cfg_wait[g*3 +: 3] = c_wait[g];
    end

    function automatic logic [7:0] mem_byte(input logic [24:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ {7'd0, a[24]} ^ 8'hA5;
    endfunction

    assign ext_din = cur_wide ? {mem_byte({ext_addr[24:1], 1'b0}), mem_byte({ext_addr[24:1], 1'b1})}
                              : {8'h00, mem_byte(ext_addr)};

    xbus_cs_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_wait(cfg_wait),
        .cfg_wide(cfg_wide), .cfg_le_en(cfg_le_en), .cfg_le_area(cfg_le_area),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_be(ext_be), .ext_dout(ext_dout), .ext_oe(ext_oe), .ext_din(ext_din)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // lowest enabled matching area, -1 when none (R1, R2)
    function automatic int ref_decode(input logic [8:0] hi);
        for (int i = 0; i < 8; i++) begin
            if (cfg_en[i] && (((hi ^ c_base[i]) & ~c_mask[i]) == 9'd0)) return i;
        end
        return -1;
    endfunction

    task automatic run_txn(input logic we, input logic [24:2] wa, input logic [3:0] be,
                           input logic [31:0] wd);
        int area, w, ne, ng, nclk, nstr, cs_bad, typ_bad, oe_bad, beat_bad;
        logic hit, wide, le;
        logic [24:0] eaddr[4];
        logic [1:0]  ebe[4];
        logic [15:0] edout[4];
        logic [31:0] erd;
        logic [24:0] gaddr[4];
        logic [1:0]  gbe[4];
        logic [15:0] gdout[4];

        area = ref_decode(wa[24:16]);
        hit  = (area >= 0);
        w    = hit ? int'(c_wait[area]) : 0;
        wide = hit ? cfg_wide[area] : 1'b0;
        le   = hit && cfg_le_en && (int'(cfg_le_area) == area);
        ne = 0;
        erd = '0;
        if (hit) begin
            if (wide) begin
                for (int b = 0; b < 2; b++) begin
                    int lh, ll;
                    lh = le ? 2*b : 3 - 2*b;
                    ll = le ? 2*b + 1 : 2 - 2*b;
                    if (be[lh] || be[ll]) begin
                        eaddr[ne] = {wa, 2'(2*b)};
                        ebe[ne]   = {be[lh], be[ll]};
                        edout[ne] = {wd[8*lh +: 8], wd[8*ll +: 8]};
                        if (be[lh]) erd[8*lh +: 8] = mem_byte({wa, 2'(2*b)});
                        if (be[ll]) erd[8*ll +: 8] = mem_byte({wa, 2'(2*b+1)});
                        ne++;
                    end
                end
            end else begin
                for (int k = 0; k < 4; k++) begin
                    int l;
                    l = le ? k : 3 - k;
                    if (be[l]) begin
                        eaddr[ne] = {wa, 2'(k)};
                        ebe[ne]   = 2'b01;
                        edout[ne] = {8'h00, wd[8*l +: 8]};
                        erd[8*l +: 8] = mem_byte({wa, 2'(k)});
                        ne++;
                    end
                end
            end
        end
        if (we) erd = '0;

        cur_wide = wide;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = wa; cpu_be = be; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        ng = 0; nclk = 0; nstr = 0; cs_bad = 0; typ_bad = 0; oe_bad = 0;
        while (!cpu_rdy && nclk < 200) begin
            if (hit) begin
                if (ext_cs_n != ~(8'd1 << area)) cs_bad++;
                if (ext_oe != we) oe_bad++;
                if (ext_rd_n && ext_wr_n) begin
                    if (ng < 4) begin
                        gaddr[ng] = ext_addr; gbe[ng] = ext_be; gdout[ng] = ext_dout;
                    end
                    ng++;
                end else begin
                    nstr++;
                    if (we ? !(ext_rd_n && !ext_wr_n) : !(!ext_rd_n && ext_wr_n)) typ_bad++;
                end
            end else begin
                if (ext_cs_n != 8'hFF || !ext_rd_n || !ext_wr_n || ext_oe) cs_bad++;
            end
            nclk++;
            @(negedge clk);
        end

        if (hit) begin
            chk(cs_bad == 0, "R1 R2 chip select", 32'(cs_bad), 0);
            chk(nstr == ne * (1 + w), "R3 strobe clocks", 32'(nstr), 32'(ne * (1 + w)));
            chk(typ_bad == 0, "R3 strobe kind", 32'(typ_bad), 0);
            chk(ng == ne, "R4 cycle count", 32'(ng), 32'(ne));
            chk(oe_bad == 0, "R7 drive enable", 32'(oe_bad), 0);
            beat_bad = 0;
            for (int j = 0; j < ne && j < ng; j++) begin
                if (gaddr[j] != eaddr[j]) begin
                    beat_bad++;
                    chk(1'b0, "R4 cycle address", 32'(gaddr[j]), 32'(eaddr[j]));
                end
                if (gbe[j] != ebe[j]) begin
                    beat_bad++;
                    chk(1'b0, "R5 byte enables", 32'(gbe[j]), 32'(ebe[j]));
                end
                if (we && gdout[j] != edout[j]) begin
                    beat_bad++;
                    chk(1'b0, "R5 R7 write lanes", 32'(gdout[j]), 32'(edout[j]));
                end
            end
            chk(beat_bad == 0, "R5 cycle contents", 32'(beat_bad), 0);
            chk(nclk == ne * (2 + w), "R8 latency", 32'(nclk), 32'(ne * (2 + w)));
        end else begin
            chk(cs_bad == 0, "R9 quiet bus on miss", 32'(cs_bad), 0);
            chk(nclk == 2, "R9 miss latency", 32'(nclk), 2);
        end
        chk(cpu_rdy == 1'b1, "R8 ready seen", 32'(cpu_rdy), 1);
        chk(cpu_rdata == erd, "R6 read data", cpu_rdata, erd);
        chk(cpu_err == !hit, "R9 error flag", 32'(cpu_err), 32'(!hit));
        @(negedge clk);
        chk(cpu_rdy == 1'b0, "R8 ready pulse", 32'(cpu_rdy), 0);
    endtask

    task automatic rand_cfg();
        cfg_en = 8'($urandom) | (8'd1 << ($urandom % 8));
        cfg_wide = 8'($urandom);
        cfg_le_en = 1'($urandom);
        cfg_le_area = 3'($urandom);
        for (int i = 0; i < 8; i++) begin
            c_base[i] = 9'($urandom);
            c_mask[i] = 9'($urandom & $urandom & $urandom);
            c_wait[i] = 3'($urandom);
        end
    endtask

    function automatic logic [3:0] rand_be();
        case ($urandom % 4)
            0: return 4'hF;
            1: return 4'd1 << ($urandom % 4);
            2: return ($urandom % 2) ? 4'b0011 : 4'b1100;
            default: return 4'($urandom % 15) + 4'd1;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            c_base[i] = '0; c_mask[i] = '0; c_wait[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R10: idle outputs during reset
        chk(ext_cs_n == 8'hFF, "R10 chip selects in reset", 32'(ext_cs_n), 32'hFF);
        chk(ext_rd_n && ext_wr_n, "R10 strobes in reset", {30'd0, ext_rd_n, ext_wr_n}, 3);
        chk(!ext_oe && !cpu_rdy, "R10 drive and ready in reset", {30'd0, ext_oe, cpu_rdy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed configuration
        cfg_en = 8'b0010_1101;
        c_base[0] = 9'h010; cfg_wide[0] = 1'b1; c_wait[0] = 3'd0;
        c_base[2] = 9'h020; cfg_wide[2] = 1'b0; c_wait[2] = 3'd7;
        c_base[3] = 9'h030; cfg_wide[3] = 1'b1; c_wait[3] = 3'd2;
        c_base[5] = 9'h020; c_mask[5] = 9'h0FF; cfg_wide[5] = 1'b1; c_wait[5] = 3'd1;
        cfg_le_en = 1'b1; cfg_le_area = 3'd3;
        @(negedge clk);

        run_txn(1'b0, {9'h010, 14'h0123}, 4'hF, 32'h0);          // R4 16-bit word read
        run_txn(1'b1, {9'h010, 14'h0040}, 4'hF, 32'h11223344);   // R7 16-bit word write
        run_txn(1'b0, {9'h020, 14'h1000}, 4'hF, 32'h0);          // R2 overlap, R3 wait 7, 8-bit
        run_txn(1'b1, {9'h020, 14'h0001}, 4'b0001, 32'hA0B0C0D0);// R4 single byte cycle
        run_txn(1'b0, {9'h030, 14'h0200}, 4'hF, 32'h0);          // R5 little-endian read
        run_txn(1'b1, {9'h030, 14'h0201}, 4'b1100, 32'hCAFE0000);// R5 little-endian half write
        run_txn(1'b0, {9'h1FF, 14'h0000}, 4'hF, 32'h0);          // R9 miss
        run_txn(1'b1, {9'h1FF, 14'h0004}, 4'hF, 32'h55555555);   // R9 miss on write
        run_txn(1'b0, {9'h021, 14'h0008}, 4'b0110, 32'h0);       // R2 area 5 when 2 does not match

        // random phase
        for (int c = 0; c < 20; c++) begin
            rand_cfg();
            @(negedge clk);
            for (int t = 0; t < 15; t++) begin
                logic [8:0] hi;
                if ($urandom % 10 < 7) begin
                    int a;
                    a = $urandom % 8;
                    while (!cfg_en[a]) a = (a + 1) % 8;
                    hi = c_base[a] ^ (9'($urandom) & c_mask[a]);
                end else begin
                    hi = 9'($urandom);
                end
                run_txn(1'($urandom), {hi, 14'($urandom)}, rand_be(), $urandom);
            end
        end
        done = 1'b1;
    end

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "watchdog expired", 32'(cyc), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule